// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block is a multi-channel pulse-width timer. Each channel owns a 16-bit down-counter and a compare register. Software never writes these directly: it fills a count buffer and a compare buffer, then pulses a per-channel update bit to copy both buffers into the live registers. The counter advances once per divided tick. Each channel has its own tick input and a prescaler that divides it by 2, 4, 8 or 16.

The output becomes active after a decrement lands on the compare value, and returns inactive at underflow. With auto-reload set, underflow reloads the counter from the count buffer, so the waveform repeats. Without auto-reload, the channel parks at zero with its output inactive. An invert bit flips the pin polarity.

All per-channel control bits share one register. Each channel uses a group of four bits. The group for channel 0 starts at bit 0, and the group for channel n (n ≥ 1) starts at bit 4n+4, which leaves bits 4..7 unused.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: After reset every readable register, every live counter and every output pin reads 0.
- R2: Within each four-bit control group, bit 0 is start, bit 1 is update, bit 2 is invert and bit 3 is auto-reload. The group starts at bit 0 for channel 0 and at bit 4n+4 for channel n ≥ 1. Control bits outside all groups read back as 0.
- R3: The divide select of channel n sits at bits 2n+1:2n of address 1. A value s gives one counter step on every 2^(s+1)-th tick. The divider restarts from zero on update, and ticks are ignored while start is clear.
- R4: While update is set, the live counter and live compare take the buffer values on the next clock edge, and no decrement happens.
- R5: Buffer writes leave the live counter and the live compare untouched until an update or a reload.
- R6: On each step, while start is set and the counter is nonzero, the counter falls by exactly one.
- R7: The output is active from the step that decrements the counter to the compare value until the underflow step. A compare equal to or above the loaded count never makes it active.
- R8: With auto-reload set, the step at zero reloads both live registers from the buffers. With count C, the period is C+1 steps.
- R9: With auto-reload clear, the channel stays at zero after step C+1 and its output stays inactive.
- R10: The invert bit turns the inactive level into 1 and the active level into 0.
- R11: With start clear, the live counter holds its value whatever ticks arrive.
- R12: The address map is as follows. Address 0 is control and address 1 is divide select. Addresses 2+2n and 3+2n are the count buffer and compare buffer of channel n. Address 2+2·NUM_CH+n is the read-only live counter of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| tick_in | input | NUM_CH | One tick pulse input per channel |
| pwm_out | output | NUM_CH | Output pin per channel |

## Verification
The bench builds the timer with two channels, so channel 1 sits at control offset 8 and the gap above channel 0 can be checked for reserved bits. The sweep covers every count from 0 to 5, every compare from 0 to 6 and all four divide ratios. Channel 0 runs with auto-reload and channel 1 runs one-shot and inverted. This covers the compare-equals-count and compare-above-count cases, the zero count and the divider boundaries at every tick. Directed sequences cover update held against ticks, buffer writes into a running channel, and halting.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int SEL_W = 2;
  localparam int DIV_W = 4;

  // one control group; packed LSB first: start, upd, inv, reload
  typedef struct packed {
    logic reload;
    logic inv;
    logic upd;
    logic start;
  } chan_ctrl_t;

  // base bit of a channel's control group in the shared register
  function automatic int ctrl_base(input int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  // last prescaler phase before a step, ratio = 2 << sel
  function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    return DIV_W'((2 << sel) - 1);
  endfunction
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [DIV_W-1:0] ph_q;
  logic             wrap;

  assign wrap   = (ph_q >= div_last(sel_i));
  assign step_o = tick_i && wrap && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= '0;
    else if (clr)    ph_q <= '0;
    else if (tick_i) ph_q <= wrap ? '0 : ph_q + 1'b1;
  end

  // R3
  step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> ph_q == '0);

  // R3
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ph_q == '0);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_ctrl_t       ctl,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_dec;
  logic             act_q;
  logic             at_zero, run_step;
  logic             dec_ev, hit_ev, under_ev, reload_ev;

  assign at_zero   = (cnt_q == '0);
  assign run_step  = !ctl.upd && ctl.start && step_i;
  assign dec_ev    = run_step && !at_zero;
  assign under_ev  = run_step && at_zero;
  assign reload_ev = under_ev && ctl.reload;
  assign cnt_dec   = cnt_q - 1'b1;
  assign hit_ev    = dec_ev && (cnt_dec == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      act_q <= 1'b0;
    end else if (ctl.upd || reload_ev) begin
      cnt_q <= cnt_buf_i;
      cmp_q <= cmp_buf_i;
      act_q <= 1'b0;
    end else if (under_ev) begin
      act_q <= 1'b0;
    end else if (dec_ev) begin
      cnt_q <= cnt_dec;
      if (hit_ev) act_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = act_q ^ ctl.inv;

  // R4
  upd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.upd |=> cnt_q == $past(cnt_buf_i) && cmp_q == $past(cmp_buf_i));

  // R6
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev |=> cnt_q == $past(cnt_q) - 1'b1);

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.start && !ctl.upd |=> $stable(cnt_q));

  // R7
  hit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> cnt_q == cmp_q);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> cnt_q == $past(cnt_buf_i) && !act_q);

  // R9
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_ev && !ctl.reload |=> cnt_q == '0 && !act_q);
endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(2 + 3 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] tick_in,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CTRL_W = ctrl_base(NUM_CH - 1) + 4;
  localparam int PSEL_W = SEL_W * NUM_CH;

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) m[ctrl_base(c) +: 4] = 4'hF;
    return m;
  endfunction

  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask();

  logic [CTRL_W-1:0] ctrl_q;
  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  cnt_buf_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_buf_q [NUM_CH];
  logic [CNT_W-1:0]  live_cnt  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psel_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        cnt_buf_q[i] <= '0;
        cmp_buf_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_MASK;
      if (wr_addr == ADDR_W'(1)) psel_q <= wr_data[PSEL_W-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_addr == ADDR_W'(2 + 2 * i)) cnt_buf_q[i] <= wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(3 + 2 * i)) cmp_buf_q[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(0)) rd_data = DATA_W'(ctrl_q);
    if (rd_addr == ADDR_W'(1)) rd_data = DATA_W'(psel_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(2 + 2 * i))          rd_data = DATA_W'(cnt_buf_q[i]);
      if (rd_addr == ADDR_W'(3 + 2 * i))          rd_data = DATA_W'(cmp_buf_q[i]);
      if (rd_addr == ADDR_W'(2 + 2 * NUM_CH + i)) rd_data = DATA_W'(live_cnt[i]);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int B = ctrl_base(g);
    chan_ctrl_t ctl;
    logic       step;
    assign ctl = chan_ctrl_t'(ctrl_q[B +: 4]);

    pwm_tick_div u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctl.upd),
      .tick_i (tick_in[g] & ctl.start),
      .sel_i  (psel_q[SEL_W*g +: SEL_W]),
      .step_o (step)
    );

    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .step_i    (step),
      .cnt_buf_i (cnt_buf_q[g]),
      .cmp_buf_i (cmp_buf_q[g]),
      .cnt_o     (live_cnt[g]),
      .pwm_o     (pwm_out[g])
    );
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/dbuf_pwm_timer_test.sv
`timescale 1ns/1ps
module dbuf_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  tick_in = '0;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbuf_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_in(tick_in), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 3'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_in = 2'b11;
    @(negedge clk);
    tick_in = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 / R12: all addresses and pins zero after reset
    for (int a = 0; a < 8; a++) begin
      rd(a, v); check("R1 reset register", v, 0);
    end
    check("R1 reset pins", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reserved control bits read 0, groups at 0 and 8
    wr(0, 16'hFFFF);
    rd(0, v); check("R2 control mask", v, 16'h0F0F);
    // R10 / R2: invert bit positions
    wr(0, 16'h0400);
    check("R10 ch1 invert pin", int'(pwm_out), 2);
    wr(0, 16'h0004);
    check("R10 ch0 invert pin", int'(pwm_out), 1);
    wr(0, 0);

    // R12: buffer addresses
    wr(2, 11); wr(3, 12); wr(4, 13); wr(5, 14); wr(1, 16'h9);
    rd(2, v); check("R12 cnt buf0", v, 11);
    rd(3, v); check("R12 cmp buf0", v, 12);
    rd(4, v); check("R12 cnt buf1", v, 13);
    rd(5, v); check("R12 cmp buf1", v, 14);
    rd(1, v); check("R12 divide select", v, 9);

    // sweep: ch0 auto-reload, ch1 one-shot inverted
    for (int c = 0; c <= 5; c++) begin
      for (int m = 0; m <= 6; m++) begin
        int sel, ratio, k, v0, v1, a0, a1;
        sel = (c + m) % 4;
        ratio = 2 << sel;
        wr(0, 0);
        wr(1, sel | (sel << 2));
        wr(2, c); wr(3, m); wr(4, c); wr(5, m);
        wr(0, 16'h070B);   // update+start both, reload ch0, invert ch1
        wr(0, 16'h0509);
        rd(6, v); check("R4 ch0 load", v, c);
        rd(7, v); check("R4 ch1 load", v, c);
        check("R10 initial pins", int'(pwm_out), 2);
        for (int t = 1; t <= ratio * (2 * (c + 1) + 1); t++) begin
          tick();
          k = t / ratio;                               // R3
          v0 = c - (k % (c + 1));                      // R6 R8
          v1 = (k >= c) ? 0 : c - k;                   // R9
          a0 = (m < c && v0 <= m) ? 1 : 0;             // R7
          a1 = (m < c && v1 <= m && k <= c) ? 1 : 0;   // R7 R9
          rd(6, v); check("R8 ch0 count", v, v0);
          rd(7, v); check("R9 ch1 count", v, v1);
          check("R7 ch0 pin", int'(pwm_out[0]), a0);
          check("R10 ch1 pin", int'(pwm_out[1]), 1 - a1);
        end
      end
    end

    // R4: update held blocks decrement, reloads buffer each edge
    wr(0, 0); wr(1, 0); wr(2, 9); wr(3, 3);
    wr(0, 16'h000B);
    for (int i = 0; i < 20; i++) tick();
    rd(6, v); check("R4 held no decrement", v, 9);
    wr(2, 7);
    @(negedge clk);
    rd(6, v); check("R4 held tracks buffer", v, 7);

    // R5: buffer writes during a run do not disturb live values
    wr(0, 16'h0009);
    tick(); tick();
    rd(6, v); check("R6 one step", v, 6);
    wr(2, 3); wr(3, 1);
    tick(); tick();
    rd(6, v); check("R5 count untouched", v, 5);
    for (int i = 0; i < 4; i++) tick();
    rd(6, v); check("R5 count at old compare", v, 3);
    check("R5 old compare still live", int'(pwm_out[0]), 1);
    for (int i = 0; i < 8; i++) tick();
    rd(6, v); check("R8 reload takes new buffer", v, 3);
    check("R7 inactive after reload", int'(pwm_out[0]), 0);

    // R11: start clear halts the counter
    wr(0, 16'h0008);
    for (int i = 0; i < 10; i++) tick();
    rd(6, v); check("R11 halted count", v, 3);
    // R3: divider frozen while halted; one more step needs two ticks
    wr(0, 16'h0009);
    tick();
    rd(6, v); check("R3 no step on first tick", v, 3);
    tick();
    rd(6, v); check("R3 step on second tick", v, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule